// File: doc/BRIEF.md
# Nested Page-Walk Address Translator

This block turns a virtual address into a physical address for a memory system that has two virtual regions: user space and system space. The user page table is not placed at a physical address. Its base lies in system virtual space. To find a user page-table entry, the block first builds that entry's system virtual address. It then translates that address through the system page table, whose physical base is fixed. Only after that does it fetch the user entry itself. A system-space request needs one lookup, taken directly from the system page table.

A requester offers one address at a time on a valid/ready handshake, together with a write flag. The translator fetches page-table entries over a simple read port that it holds until it gets an acknowledge. It returns a one-cycle response carrying the physical address or a fault code. Pages are 512 bytes and entries are 4 bytes. Every entry has the same layout: a valid flag, a modified flag, a 2-bit permission field and a frame number. The two table bases are configuration inputs and must stay steady while a walk is running.

Top module: `xlat_walker`

## Requirements
- R1: After reset, req_ready is 1, mem_req is 0 and rsp_valid is 0.
- R2: A request with va[31:30]=00 (user space) forms the entry VA as user_base + 4*va[29:9]. It first reads sys_base + 4*entryVA[29:9], then reads {sysPTE[22:0], entryVA[8:0]}, in that order.
- R3: A successful user translation returns rsp_pa = {userPTE[22:0], va[8:0]} with rsp_fault = 0.
- R4: A request with va[31:30]=10 (system space) does exactly one read, at sys_base + 4*va[29:9], and returns {sysPTE[22:0], va[8:0]}.
- R5: A request with va[31:30] of 01 or 11 returns fault code 1 without any read. Every faulting response carries rsp_pa = 0.
- R6: If the user entry VA does not have bits 31:30 = 10, the response is fault code 5 and no read is made.
- R7: A system PTE with bit 31 = 0 returns fault code 2 at once, and the second read is skipped.
- R8: A user PTE with bit 31 = 0 returns fault code 3.
- R9: The permission field is bits 29:28 of the final PTE only. 00 denies all access, 01 allows reads only, and 10 or 11 allow reads and writes. A denied access returns fault code 4. Bit 30 (modified) has no effect on the result.
- R10: req_ready stays 0 from the acceptance edge through the response cycle. rsp_valid lasts one cycle. A req_valid raised while busy is ignored.
- R11: Once mem_req is raised, it stays high and mem_addr stays steady until the cycle in which mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_user_base | input | 32 | User page-table base (system virtual address) |
| cfg_sys_base | input | 32 | System page-table base (physical address) |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | Request is a write |
| req_va | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Translator idle, request accepted on this edge |
| mem_req | output | 1 | Page-table read outstanding |
| mem_addr | output | 32 | Physical address of the entry being read |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Page-table entry read back |
| rsp_valid | output | 1 | Response pulse |
| rsp_pa | output | 32 | Translated physical address (0 on fault) |
| rsp_fault | output | 3 | 0 none, 1 bad region, 2 system PTE invalid, 3 user PTE invalid, 4 access denied, 5 user table outside system space |

## Verification
The bench builds the translator with its default 32-bit address and 9-bit page offset. With these values the region bits, the 21-bit page numbers and the 23-bit frame fields line up with hand-computed table placements, including the largest user page number. The bench's memory model runs first with zero added latency and then with three wait cycles. This exercises both back-to-back reads and a held read request. Moving the user table base into user space reaches the table-region fault.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_REGION  = 3'd1,
    FLT_SYS_INV = 3'd2,
    FLT_USR_INV = 3'd3,
    FLT_ACCESS  = 3'd4,
    FLT_TBL_REG = 3'd5
  } xlat_fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SYS,
    ST_USR,
    ST_DONE
  } xlat_state_e;

  localparam logic [1:0] SPACE_USER = 2'b00;
  localparam logic [1:0] SPACE_SYS  = 2'b10;

  localparam int PTE_W     = 32;
  localparam int PTE_VALID = 31;
  localparam int PTE_ACC_H = 29;
  localparam int PTE_ACC_L = 28;
endpackage

// File: rtl/xlat_rst_sync.sv
module xlat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/xlat_pte_addr.sv
module xlat_pte_addr #(
  parameter int AW  = 32,
  parameter int VPW = 21
) (
  input  logic [AW-1:0]  base,
  input  logic [VPW-1:0] vpn,
  output logic [AW-1:0]  addr
);
  localparam int PAD = AW - VPW - 2;

  assign addr = base + {{PAD{1'b0}}, vpn, 2'b00};
endmodule

// File: rtl/xlat_pte_check.sv
module xlat_pte_check
  import xlat_pkg::*;
#(
  parameter int PFN_W = 23
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             is_write,
  output logic             present,
  output logic             allowed,
  output logic [PFN_W-1:0] pfn
);
  logic [1:0] perm;

  assign perm    = pte[PTE_ACC_H:PTE_ACC_L];
  assign present = pte[PTE_VALID];
  assign allowed = (perm != 2'b00) && (!is_write || perm[1]);
  assign pfn     = pte[PFN_W-1:0];
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int AW = 32,
  parameter int PB = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_user_base,
  input  logic [AW-1:0] cfg_sys_base,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_va,
  output logic          req_ready,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_pa,
  output logic [2:0]    rsp_fault
);
  localparam int VPW   = AW - 2 - PB;
  localparam int PFN_W = AW - PB;

  logic rst_i_n;
  xlat_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  xlat_state_e state_q, state_d;
  logic [AW-1:0]    va_q, tva_q, tva_calc, sys_addr, pa_q, pa_d;
  logic             wr_q, user_q;
  logic [PFN_W-1:0] upfn_q;
  xlat_fault_e      fault_q, fault_d;
  logic             ld_req, ld_upfn, ld_rsp;
  logic [VPW-1:0]   sys_vpn;
  logic             pte_present, pte_allowed;
  logic [PFN_W-1:0] pte_pfn;
  logic [1:0]       in_space;

  assign in_space = req_va[AW-1:AW-2];

  // user entry VA from the incoming request
  xlat_pte_addr #(.AW(AW), .VPW(VPW)) u_tva (
    .base(cfg_user_base), .vpn(req_va[AW-3:PB]), .addr(tva_calc));

  // system entry physical address for whichever VA the walk is resolving
  assign sys_vpn = user_q ? tva_q[AW-3:PB] : va_q[AW-3:PB];
  xlat_pte_addr #(.AW(AW), .VPW(VPW)) u_sva (
    .base(cfg_sys_base), .vpn(sys_vpn), .addr(sys_addr));

  xlat_pte_check #(.PFN_W(PFN_W)) u_chk (
    .pte(mem_rdata), .is_write(wr_q),
    .present(pte_present), .allowed(pte_allowed), .pfn(pte_pfn));

  always_comb begin
    state_d = state_q;
    ld_req  = 1'b0;
    ld_upfn = 1'b0;
    ld_rsp  = 1'b0;
    pa_d    = '0;
    fault_d = FLT_NONE;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        ld_req = 1'b1;
        if (in_space == SPACE_USER) begin
          if (tva_calc[AW-1:AW-2] == SPACE_SYS) state_d = ST_SYS;
          else begin
            fault_d = FLT_TBL_REG; ld_rsp = 1'b1; state_d = ST_DONE;
          end
        end else if (in_space == SPACE_SYS) begin
          state_d = ST_SYS;
        end else begin
          fault_d = FLT_REGION; ld_rsp = 1'b1; state_d = ST_DONE;
        end
      end
      ST_SYS: if (mem_ack) begin
        if (!pte_present) begin
          fault_d = FLT_SYS_INV; ld_rsp = 1'b1; state_d = ST_DONE;
        end else if (user_q) begin
          ld_upfn = 1'b1; state_d = ST_USR;
        end else begin
          ld_rsp  = 1'b1; state_d = ST_DONE;
          if (pte_allowed) pa_d = {pte_pfn, va_q[PB-1:0]};
          else             fault_d = FLT_ACCESS;
        end
      end
      ST_USR: if (mem_ack) begin
        ld_rsp  = 1'b1; state_d = ST_DONE;
        if (!pte_present)      fault_d = FLT_USR_INV;
        else if (!pte_allowed) fault_d = FLT_ACCESS;
        else                   pa_d = {pte_pfn, va_q[PB-1:0]};
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (ld_req) begin
      va_q   <= req_va;
      wr_q   <= req_write;
      user_q <= (in_space == SPACE_USER);
      tva_q  <= tva_calc;
    end
    if (ld_upfn) upfn_q <= pte_pfn;
    if (ld_rsp) begin
      pa_q    <= pa_d;
      fault_q <= fault_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_SYS) || (state_q == ST_USR);
  assign mem_addr  = (state_q == ST_USR) ? {upfn_q, tva_q[PB-1:0]} : sys_addr;
  assign rsp_valid = (state_q == ST_DONE);
  assign rsp_pa    = pa_q;
  assign rsp_fault = fault_q;

  assert_read_held_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_valid |=> !rsp_valid);
  assert_busy_rsp_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_valid |-> !req_ready && !mem_req);
  assert_bad_space_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_ready && req_valid && in_space[0] |=> rsp_valid && !mem_req && rsp_fault == FLT_REGION);
  assert_fault_pa_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_valid && rsp_fault != FLT_NONE |-> rsp_pa == '0);
  assert_sys_inv_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    state_q == ST_SYS && mem_ack && !mem_rdata[31] |=> rsp_valid && rsp_fault == FLT_SYS_INV);
endmodule

// File: tb/xlat_walker_test.sv
module xlat_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_user_base = 32'h8000_0400;
  logic [31:0] cfg_sys_base  = 32'h0001_0000;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready, mem_req, rsp_valid;
  logic [31:0] mem_addr, rsp_pa;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [2:0]  rsp_fault;

  always #2.5 clk = ~clk;

  xlat_walker uut (.*);

  int checks = 0, failures = 0, cyc = 0, lat = 0, cnt = 0;
  bit model_busy = 0, finished = 0;
  logic [31:0] mem_img [int unsigned];
  int unsigned exp_rd_q [$];
  logic [31:0] exp_pa;
  int          exp_fault;
  string       exp_tag;

  function automatic logic [31:0] rd(int unsigned a);
    return mem_img.exists(a) ? mem_img[a] : 32'h0;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pte(int v, int acc, int pfn);
    return {v[0], 1'b0, acc[1:0], 5'b0, pfn[22:0]};
  endfunction

  // reference walk: fills expected reads and result
  task automatic model(logic [31:0] va, bit wr);
    logic [31:0] tva, sa, ua, e;
    int acc;
    exp_rd_q.delete();
    exp_pa = 0;
    exp_fault = 0;
    if (va[31:30] == 2'b00) begin
      tva = cfg_user_base + (va[29:9] * 4);
      if (tva[31:30] != 2'b10) begin exp_fault = 5; return; end
      sa = cfg_sys_base + (tva[29:9] * 4);
      exp_rd_q.push_back(sa);
      e = rd(sa);
      if (!e[31]) begin exp_fault = 2; return; end
      ua = {e[22:0], tva[8:0]};
      exp_rd_q.push_back(ua);
      e = rd(ua);
      if (!e[31]) begin exp_fault = 3; return; end
    end else if (va[31:30] == 2'b10) begin
      sa = cfg_sys_base + (va[29:9] * 4);
      exp_rd_q.push_back(sa);
      e = rd(sa);
      if (!e[31]) begin exp_fault = 2; return; end
    end else begin
      exp_fault = 1; return;
    end
    acc = e[29:28];
    if (acc == 0 || (wr && acc == 1)) exp_fault = 4;
    else exp_pa = {e[22:0], va[8:0]};
  endtask

  // place a system PTE and a user PTE so that user address va resolves
  task automatic map_user(logic [31:0] va, int spfn, logic [31:0] upte);
    logic [31:0] tva;
    tva = cfg_user_base + (va[29:9] * 4);
    mem_img[cfg_sys_base + tva[29:9] * 4] = pte(1, 2, spfn);
    mem_img[{spfn[22:0], tva[8:0]}] = upte;
  endtask

  task automatic run(logic [31:0] va, bit wr, string tag, bit stray = 0);
    int w;
    model(va, wr);
    exp_tag = tag;
    @(negedge clk);
    req_va = va; req_write = wr; req_valid = 1'b1;
    @(posedge clk);
    #1 model_busy = 1;
    @(negedge clk);
    req_valid = 1'b0;
    if (stray && model_busy) begin
      req_va = 32'h4000_0000; req_valid = 1'b1;
      @(negedge clk); @(negedge clk);
      req_valid = 1'b0;
    end
    w = 0;
    while (model_busy && w < 200) begin @(negedge clk); w++; end
    check(!model_busy, tag, "no response", 0, 1);
    model_busy = 0;
  endtask

  // memory model and per-cycle comparison
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0; cnt <= 0;
    end else if (mem_req) begin
      if (exp_rd_q.size() == 0) check(0, exp_tag, "unexpected read", mem_addr, 0);
      else begin
        check(mem_addr == exp_rd_q[0], exp_tag, "read address (R2 R11)", mem_addr, exp_rd_q[0]);
        if (cnt >= lat) begin
          mem_rdata <= rd(mem_addr); mem_ack <= 1'b1;
          void'(exp_rd_q.pop_front());
        end else cnt <= cnt + 1;
      end
    end
    if (model_busy) begin
      check(!req_ready, "R10", "ready while busy", req_ready, 0);
      if (rsp_valid) begin
        check(rsp_fault == exp_fault[2:0], exp_tag, "fault code", rsp_fault, exp_fault);
        check(rsp_pa == exp_pa, exp_tag, "physical address", rsp_pa, exp_pa);
        check(exp_rd_q.size() == 0, exp_tag, "reads missing", exp_rd_q.size(), 0);
        model_busy = 0;
      end
    end else if (rst_n && cyc > 4) begin
      check(!rsp_valid, "R10", "unexpected response", rsp_valid, 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    check(mem_req == 1'b0, "R1", "mem_req", mem_req, 0);
    check(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);

    for (int pass = 0; pass < 2; pass++) begin
      lat = (pass == 0) ? 0 : 3;
      mem_img.delete();
      map_user(32'h0000_0AAB, 23'h0123, pte(1, 2, 23'h4567));
      run(32'h0000_0AAB, 0, "R3");
      run(32'h0000_0AAB, 1, "R2");
      map_user(32'h0000_1C00, 23'h0123, pte(1, 1, 23'h0777));
      run(32'h0000_1C00, 1, "R9");
      run(32'h0000_1C00, 0, "R9");
      map_user(32'h0000_2000, 23'h0123, pte(1, 0, 23'h0777));
      run(32'h0000_2000, 0, "R9");
      map_user(32'h0000_2200, 23'h0123, pte(1, 3, 23'h0055) | 32'h4000_0000);
      run(32'h0000_2200, 1, "R9");
      map_user(32'h3FFF_FFFF, 23'h7FFFFF, pte(1, 2, 23'h7FFFFF));
      run(32'h3FFF_FFFF, 0, "R3");
      mem_img[cfg_sys_base + 5 * 4] = pte(1, 1, 23'h0ABC);
      run(32'h8000_0A10, 0, "R4");
      run(32'h8000_0A10, 1, "R9");
      run(32'h4000_0100, 0, "R5");
      run(32'hC000_0100, 1, "R5");
      run(32'h0002_5800, 0, "R7");
      map_user(32'h0000_3000, 23'h0123, pte(0, 2, 23'h0999));
      run(32'h0000_3000, 0, "R8");
      map_user(32'h0000_0600, 23'h0123, pte(1, 2, 23'h0321));
      run(32'h0000_0600, 0, "R10", 1);
      cfg_user_base = 32'h0000_0400;
      run(32'h0000_0AAB, 0, "R6");
      cfg_user_base = 32'h8000_0400;
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule